// File: doc/BRIEF.md
# Enhanced Parallel Port Host Cycle Engine

This block runs single host-side transfers on an enhanced-mode parallel port with an 8-bit bidirectional address/data bus. The local side presents one request at a time: a direction flag (write or read), a select flag choosing an address cycle or a data cycle, and the byte to send. The engine answers with a one-cycle response that carries the read byte and a timeout flag.

On the port side the engine drives an active-low write-direction line, two active-low strobes (one for address cycles, one for data cycles), an active-low device reset, and the enable of the bus output drivers. The peripheral paces every transfer through an active-low wait line. Low means it is ready to start. A rise means it has finished. The engine also watches an active-high interrupt input and keeps its rising edges in a pending flag until the local side clears it. Both asynchronous port inputs pass through two flip-flops before any logic uses them.

A local reset command holds the device reset low for a programmable number of clocks. Both handshake phases are guarded by a programmable clock limit. If the limit expires, the transfer is dropped and a timeout is reported.

Top module: `epp_host_engine`

## Requirements
- R1: In a write transfer (req_write=1), n_write is low, pd_oe is high and pd_out equals the request byte for as long as the strobe is low.
- R2: In a read transfer (req_write=0), n_write is high and pd_oe is low while the strobe is low. resp_rdata returns the pd_in value present when the synchronised wait line rises.
- R3: req_addr=1 selects n_astrb and req_addr=0 selects n_dstrb. The two strobes are never low together.
- R4: No strobe falls while the synchronised wait input is high. A strobe falls only after wait_n is seen low.
- R5: After wait_n rises during a strobe, the strobe returns high and resp_valid pulses for exactly one cycle with resp_timeout=0.
- R6: If the ready phase or the strobe phase lasts cfg_timeout+1 clocks without the expected wait level, the transfer ends. resp_valid pulses with resp_timeout=1 and both strobes and pd_oe are released.
- R7: A request that arrives while busy=1 is ignored. It does not alter the running transfer and does not start a later one.
- R8: A one-cycle rst_cmd in idle holds n_reset low for exactly cfg_rst_len clocks (a value of 0 acts as 1). rst_cmd wins over a simultaneous request, and no transfer starts while n_reset is low.
- R9: A rising edge on intr sets intr_pending, which stays set until intr_clear. While intr is held high, clearing leaves the flag low.
- R10: After rst, the strobes, n_write and n_reset are high, pd_oe is low, and busy, resp_valid and intr_pending are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_addr | input | 1 | 1 = address cycle, 0 = data cycle |
| req_wdata | input | 8 | Byte to write |
| rst_cmd | input | 1 | Start a device reset pulse |
| cfg_timeout | input | 16 | Handshake limit in clocks (phase lasts this +1) |
| cfg_rst_len | input | 16 | Device reset pulse length in clocks |
| busy | output | 1 | Transfer or reset pulse in progress |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_timeout | output | 1 | Completion was a timeout |
| resp_rdata | output | 8 | Byte captured by the last read |
| intr_clear | input | 1 | Clear the interrupt pending flag |
| intr_pending | output | 1 | Sticky interrupt edge flag |
| pd_in | input | 8 | Bus value seen at the pins |
| pd_out | output | 8 | Bus value driven by the host |
| pd_oe | output | 1 | Host bus driver enable (low = released) |
| n_write | output | 1 | Active-low write direction |
| n_dstrb | output | 1 | Active-low data strobe |
| n_astrb | output | 1 | Active-low address strobe |
| n_reset | output | 1 | Active-low device reset |
| wait_n | input | 1 | Peripheral handshake, active low |
| intr | input | 1 | Peripheral interrupt, active high |

## Verification
The bench holds wait_n high while a request is pending. A design that strobes without the ready level would drop a strobe early. It counts how many clocks each phase survives before a timeout, which exposes an off-by-one limit or a design that leaves a strobe or the bus drivers on after aborting. It injects a second request in the middle of a transfer and checks both the bus and the following idle period, so a design that latches late requests shows a corrupted byte or an extra strobe. It measures the device reset pulse at lengths 5 and 0, and it clears a pending interrupt while the input stays high, which catches a level-triggered flag that comes straight back.

// File: rtl/epp_host_pkg.sv
package epp_host_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST,
        ST_READY,
        ST_SETUP,
        ST_STROBE
    } epp_state_e;

    typedef struct packed {
        logic              write;
        logic              addr;
        logic [BYTE_W-1:0] data;
    } epp_req_t;

    function automatic logic strobe_phase(input epp_state_e st);
        return st == ST_STROBE;
    endfunction

    function automatic logic drive_phase(input epp_state_e st);
        return (st == ST_SETUP) || (st == ST_STROBE);
    endfunction

endpackage

// File: rtl/epp_sync2.sv
module epp_sync2 #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/epp_irq_capture.sv
module epp_irq_capture (
    input  logic clk,
    input  logic rst,
    input  logic intr_s,
    input  logic clear,
    output logic pending
);
    logic intr_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            intr_prev <= 1'b0;
            pending   <= 1'b0;
        end else begin
            intr_prev <= intr_s;
            pending   <= (pending & ~clear) | (intr_s & ~intr_prev);
        end
    end

    a_r9_pending_sticky: assert property (@(posedge clk) disable iff (rst)
        (pending && !clear) |=> pending);
    a_r9_clear_without_edge: assert property (@(posedge clk) disable iff (rst)
        (clear && intr_prev && intr_s) |=> !pending);
endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
    import epp_host_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  epp_req_t          req_in,
    input  logic              rst_cmd,
    input  logic [CNT_W-1:0]  cfg_timeout,
    input  logic [CNT_W-1:0]  cfg_rst_len,
    input  logic              wait_s,
    input  logic [BYTE_W-1:0] pd_in,
    output logic              busy,
    output logic              resp_valid,
    output logic              resp_timeout,
    output logic [BYTE_W-1:0] resp_rdata,
    output logic [BYTE_W-1:0] pd_out,
    output logic              pd_oe,
    output logic              n_write,
    output logic              n_dstrb,
    output logic              n_astrb,
    output logic              n_reset
);
    epp_state_e       state;
    epp_req_t         req_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] rst_last;

    assign rst_last = (cfg_rst_len == '0) ? '0 : cfg_rst_len - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            req_q        <= '0;
            cnt          <= '0;
            resp_valid   <= 1'b0;
            resp_timeout <= 1'b0;
            resp_rdata   <= '0;
        end else begin
            resp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (rst_cmd) begin
                        state <= ST_RST;
                    end else if (req_valid) begin
                        req_q <= req_in;
                        state <= ST_READY;
                    end
                end
                ST_RST: begin
                    if (cnt >= rst_last) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_READY: begin
                    if (!wait_s) begin
                        state <= ST_SETUP;
                    end else if (cnt == cfg_timeout) begin
                        state        <= ST_IDLE;
                        resp_valid   <= 1'b1;
                        resp_timeout <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SETUP: begin
                    state <= ST_STROBE;
                    cnt   <= '0;
                end
                ST_STROBE: begin
                    if (wait_s) begin
                        if (!req_q.write) resp_rdata <= pd_in;
                        state        <= ST_IDLE;
                        resp_valid   <= 1'b1;
                        resp_timeout <= 1'b0;
                    end else if (cnt == cfg_timeout) begin
                        state        <= ST_IDLE;
                        resp_valid   <= 1'b1;
                        resp_timeout <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy    = (state != ST_IDLE);
        n_reset = (state != ST_RST);
        pd_oe   = drive_phase(state) && req_q.write;
        n_write = !pd_oe;
        pd_out  = pd_oe ? req_q.data : '0;
        n_dstrb = !(strobe_phase(state) && !req_q.addr);
        n_astrb = !(strobe_phase(state) &&  req_q.addr);
    end

    a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        (n_dstrb || n_astrb));
    a_r1_write_drives_bus: assert property (@(posedge clk) disable iff (rst)
        ((!n_dstrb || !n_astrb) && !n_write) |-> pd_oe);
    a_r2_read_releases_bus: assert property (@(posedge clk) disable iff (rst)
        ((!n_dstrb || !n_astrb) && n_write) |-> !pd_oe);
    a_r5_done_releases_strobes: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (n_dstrb && n_astrb && !busy));
    a_r6_abort_releases_bus: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_timeout) |-> (n_dstrb && n_astrb && !pd_oe));
    a_r7_request_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(req_q));
    a_r8_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        !n_reset |-> (n_dstrb && n_astrb && !pd_oe));
endmodule

// File: rtl/epp_host_engine.sv
module epp_host_engine
    import epp_host_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_addr,
    input  logic [BYTE_W-1:0] req_wdata,
    input  logic              rst_cmd,
    input  logic [CNT_W-1:0]  cfg_timeout,
    input  logic [CNT_W-1:0]  cfg_rst_len,
    output logic              busy,
    output logic              resp_valid,
    output logic              resp_timeout,
    output logic [BYTE_W-1:0] resp_rdata,
    input  logic              intr_clear,
    output logic              intr_pending,
    input  logic [BYTE_W-1:0] pd_in,
    output logic [BYTE_W-1:0] pd_out,
    output logic              pd_oe,
    output logic              n_write,
    output logic              n_dstrb,
    output logic              n_astrb,
    output logic              n_reset,
    input  logic              wait_n,
    input  logic              intr
);
    logic [1:0] pins_s;
    epp_req_t   req_in;

    assign req_in = '{write: req_write, addr: req_addr, data: req_wdata};

    epp_sync2 #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({intr, wait_n}),
        .q   (pins_s)
    );

    epp_irq_capture u_irq (
        .clk     (clk),
        .rst     (rst),
        .intr_s  (pins_s[1]),
        .clear   (intr_clear),
        .pending (intr_pending)
    );

    epp_cycle_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_in       (req_in),
        .rst_cmd      (rst_cmd),
        .cfg_timeout  (cfg_timeout),
        .cfg_rst_len  (cfg_rst_len),
        .wait_s       (pins_s[0]),
        .pd_in        (pd_in),
        .busy         (busy),
        .resp_valid   (resp_valid),
        .resp_timeout (resp_timeout),
        .resp_rdata   (resp_rdata),
        .pd_out       (pd_out),
        .pd_oe        (pd_oe),
        .n_write      (n_write),
        .n_dstrb      (n_dstrb),
        .n_astrb      (n_astrb),
        .n_reset      (n_reset)
    );
endmodule

// File: tb/sim_epp_host_engine.sv
module sim_epp_host_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 0, req_write = 0, req_addr = 0;
    logic [7:0]  req_wdata = 0;
    logic        rst_cmd = 0;
    logic [15:0] cfg_timeout = 16'd50;
    logic [15:0] cfg_rst_len = 16'd5;
    logic        busy, resp_valid, resp_timeout;
    logic [7:0]  resp_rdata;
    logic        intr_clear = 0, intr_pending;
    logic [7:0]  pd_in = 0, pd_out;
    logic        pd_oe, n_write, n_dstrb, n_astrb, n_reset;
    logic        wait_n = 1'b1, intr = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    epp_host_engine u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rst_cmd(rst_cmd),
        .cfg_timeout(cfg_timeout), .cfg_rst_len(cfg_rst_len), .busy(busy),
        .resp_valid(resp_valid), .resp_timeout(resp_timeout),
        .resp_rdata(resp_rdata), .intr_clear(intr_clear),
        .intr_pending(intr_pending), .pd_in(pd_in), .pd_out(pd_out),
        .pd_oe(pd_oe), .n_write(n_write), .n_dstrb(n_dstrb),
        .n_astrb(n_astrb), .n_reset(n_reset), .wait_n(wait_n), .intr(intr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    task automatic issue(input logic wr, input logic ad, input logic [7:0] wd);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = ad; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_strobe(output int n);
        n = 0;
        while (n_dstrb && n_astrb && n < 40) begin @(negedge clk); n++; end
    endtask

    task automatic wait_resp(output int n);
        n = 0;
        while (!resp_valid && n < 40) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset_state();
        check(n_dstrb && n_astrb && n_write && n_reset, "R10", "idle port lines high",
              {n_dstrb, n_astrb, n_write, n_reset}, 15);
        check(!pd_oe && !busy && !resp_valid && !intr_pending, "R10", "idle flags low",
              {pd_oe, busy, resp_valid, intr_pending}, 0);
    endtask

    task automatic t_transfer(input logic wr, input logic ad, input logic [7:0] wd,
                              input logic [7:0] rd);
        int n;
        string rq;
        rq = wr ? "R1" : "R2";
        wait_n = 0; pd_in = rd;
        issue(wr, ad, wd);
        wait_strobe(n);
        check(n < 40, "R4", "strobe reached after ready", n, 0);
        if (ad) check(!n_astrb && n_dstrb, "R3", "address strobe chosen", {n_astrb, n_dstrb}, 1);
        else    check(!n_dstrb && n_astrb, "R3", "data strobe chosen", {n_astrb, n_dstrb}, 2);
        check(n_write == !wr && pd_oe == wr, rq, "direction and driver", {n_write, pd_oe}, {!wr, wr});
        if (wr) check(pd_out == wd, "R1", "bus byte", pd_out, wd);
        repeat (3) @(negedge clk);
        check(!(n_dstrb && n_astrb), "R5", "strobe held until acknowledge", {n_astrb, n_dstrb}, 0);
        if (wr) check(pd_out == wd && !n_write, "R1", "bus held through strobe", pd_out, wd);
        wait_n = 1;
        wait_resp(n);
        check(n < 40 && !resp_timeout, "R5", "clean completion", resp_timeout, 0);
        check(n_dstrb && n_astrb && !pd_oe, "R5", "strobes released at completion",
              {n_dstrb, n_astrb, pd_oe}, 6);
        if (!wr) check(resp_rdata == rd, "R2", "captured read byte", resp_rdata, rd);
        @(negedge clk);
        check(!resp_valid, "R5", "response one cycle", resp_valid, 0);
        wait_n = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_wait_gating();
        int bad = 0;
        int n;
        wait_n = 1;
        issue(1'b0, 1'b0, 8'h00);
        repeat (10) begin
            @(negedge clk);
            if (!(n_dstrb && n_astrb)) bad++;
        end
        check(bad == 0, "R4", "no strobe while wait high", bad, 0);
        wait_n = 0; pd_in = 8'h3C;
        wait_strobe(n);
        check(n < 40, "R4", "strobe after wait low", n, 0);
        wait_n = 1;
        wait_resp(n);
        check(resp_rdata == 8'h3C && !resp_timeout, "R2", "gated read byte", resp_rdata, 8'h3C);
        wait_n = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_timeout_ready();
        int n = 0;
        int strobes = 0;
        cfg_timeout = 16'd7;
        wait_n = 1;
        issue(1'b1, 1'b0, 8'hA5);
        while (busy && n < 100) begin
            if (!(n_dstrb && n_astrb)) strobes++;
            n++; @(negedge clk);
        end
        check(n == 8, "R6", "ready phase length", n, 8);
        check(resp_valid && resp_timeout, "R6", "timeout reported", {resp_valid, resp_timeout}, 3);
        check(strobes == 0 && !pd_oe, "R6", "no strobe in ready timeout", strobes, 0);
        wait_n = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_timeout_strobe();
        int n;
        cfg_timeout = 16'd7;
        wait_n = 0;
        issue(1'b1, 1'b1, 8'h5A);
        wait_strobe(n);
        n = 0;
        while (!(n_dstrb && n_astrb) && n < 100) begin n++; @(negedge clk); end
        check(n == 8, "R6", "strobe phase length", n, 8);
        check(resp_valid && resp_timeout, "R6", "strobe timeout reported", {resp_valid, resp_timeout}, 3);
        check(!pd_oe && n_write, "R6", "bus released after abort", {pd_oe, n_write}, 1);
        cfg_timeout = 16'd50;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_busy_ignore();
        int n;
        int extra = 0;
        wait_n = 0;
        issue(1'b1, 1'b0, 8'hC3);
        wait_strobe(n);
        issue(1'b0, 1'b1, 8'h11);
        check(pd_out == 8'hC3 && !n_dstrb && n_astrb, "R7", "running transfer unchanged",
              pd_out, 8'hC3);
        wait_n = 1;
        wait_resp(n);
        wait_n = 0;
        repeat (12) begin
            @(negedge clk);
            if (!(n_dstrb && n_astrb) || resp_valid || busy) extra++;
        end
        check(extra == 0, "R7", "late request dropped", extra, 0);
    endtask

    task automatic t_reset_pulse(input logic [15:0] len, input int expect_n);
        int n = 0;
        int strobes = 0;
        cfg_rst_len = len;
        wait_n = 0;
        @(negedge clk);
        rst_cmd = 1; req_valid = 1; req_write = 1; req_addr = 0; req_wdata = 8'h77;
        @(negedge clk);
        rst_cmd = 0; req_valid = 0;
        while (!n_reset && n < 100) begin
            if (n == 0) req_valid = 1;
            else req_valid = 0;
            if (!(n_dstrb && n_astrb)) strobes++;
            n++; @(negedge clk);
        end
        req_valid = 0;
        check(n == expect_n, "R8", "device reset length", n, expect_n);
        repeat (6) begin
            @(negedge clk);
            if (!(n_dstrb && n_astrb) || busy) strobes++;
        end
        check(strobes == 0, "R8", "no transfer around reset pulse", strobes, 0);
    endtask

    task automatic t_irq();
        @(negedge clk); intr = 1;
        repeat (5) @(negedge clk);
        check(intr_pending, "R9", "edge captured", intr_pending, 1);
        repeat (5) @(negedge clk);
        check(intr_pending, "R9", "flag sticky", intr_pending, 1);
        intr_clear = 1; @(negedge clk); intr_clear = 0;
        repeat (5) @(negedge clk);
        check(!intr_pending, "R9", "clear with input high", intr_pending, 0);
        intr = 0; repeat (4) @(negedge clk);
        intr = 1; repeat (5) @(negedge clk);
        check(intr_pending, "R9", "second edge captured", intr_pending, 1);
        intr = 0;
        intr_clear = 1; @(negedge clk); intr_clear = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset_state();
        t_transfer(1'b1, 1'b0, 8'h96, 8'h00);
        t_transfer(1'b1, 1'b1, 8'h0F, 8'h00);
        t_transfer(1'b0, 1'b0, 8'h00, 8'hE1);
        t_transfer(1'b0, 1'b1, 8'h00, 8'h42);
        t_wait_gating();
        t_timeout_ready();
        t_timeout_strobe();
        t_busy_ignore();
        t_reset_pulse(16'd5, 5);
        t_reset_pulse(16'd0, 1);
        t_irq();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule